// File: doc/BRIEF.md
# Asynchronous Peripheral Access Sequencer

This block turns single read or write requests from a synchronous host-side slave port into timed access cycles on an external asynchronous peripheral bus. The bus carries an address, active-low byte-lane enables, an active-high address strobe, an active-low chip select, active-low read and write strobes, a split data bus (output word, output enable, input word) and an active-high device-ready input.

Every physical timing figure is a picosecond parameter. At elaboration each one is divided by the bus clock period parameter, rounded up and clamped to at least one clock. Several figures are merged with a maximum before conversion. An access runs through these phases in order: address, data setup (writes only), ready wait, strobe, hold and acknowledge. A device that never signals ready is abandoned after a bounded wait, and the host sees an error. Back-to-back accesses of the same kind are held apart by a minimum cycle time.

The host holds `hostValid` and its fields steady until `hostAck` pulses for one cycle. The response sits on `hostRdata` and `hostErr` during that cycle.

Top module: `async_bus_seq`

## Requirements
- R1: Every phase count is ceil(parameter_ps / CLK_PERIOD_PS), with a minimum of 1; a parameter of 0 gives 1 clock.
- R2: `busAds` is high for exactly max(address setup, strobe width, select width) converted clocks. This starts in the clock after the accepting edge, with `busCsN` low from that same clock.
- R3: After the strobe (or after a timed-out wait), select, address and byte enables stay driven for a hold of max(data hold, select hold, address hold) clocks on writes. On reads the hold is the larger of that and the converted data-invalid time. `busAddr` does not change while `busCsN` is low.
- R4: On a read, `busRdN` is low for the converted read width. `hostRdata` is the `busDin` value sampled at the end of strobe cycle min(data-out count, read count), counting from 1.
- R5: On a write, `busWrN` is low for the converted write width. `busOe` is high with `busDout` equal to the write word from the first setup cycle to the last hold cycle, and never during reads.
- R6: A ready-wait phase follows the address phase on reads, or the setup phase on writes. The strobe starts in the clock after the first wait clock that sees `busRdy` high, so the wait lasts at least 1 clock.
- R7: If `busRdy` stays low for the converted maximum-wait count of clocks, no strobe is issued and the hold phase follows. The access then completes with `hostErr` = 1 and `hostRdata` = 0.
- R8: The address phase of a read starts at least the converted read cycle time after the previous read's address phase started, and likewise for writes with the write cycle time. A read and a write do not constrain each other.
- R9: `hostAck` is high for one clock, one clock after `busCsN` returns high. `busAddr` and `busBeN` (the bitwise inverse of `hostBe`) are driven throughout the select period. A new request can be accepted in the clock after the acknowledge.
- R10: During and right after reset, `busCsN`, `busRdN` and `busWrN` are high, and `busAds`, `busOe` and `hostAck` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host request pending |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Request address |
| hostWdata | input | DATA_W | Write word |
| hostBe | input | BE_W | Byte-lane enables, active high |
| hostAck | output | 1 | One-clock completion pulse |
| hostRdata | output | DATA_W | Read word (0 on timeout) |
| hostErr | output | 1 | Ready timeout flag |
| busAddr | output | ADDR_W | Peripheral address |
| busBeN | output | BE_W | Byte-lane enables, active low |
| busAds | output | 1 | Address strobe, active high |
| busCsN | output | 1 | Chip select, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busDout | output | DATA_W | Write data to the bus |
| busOe | output | 1 | Data output enable |
| busDin | input | DATA_W | Read data from the bus |
| busRdy | input | 1 | Device ready |

## Verification
An access accepted at one edge puts the address phase in the next clock. It acknowledges L+1 clocks after that, where L is the sum of the address, setup, wait, strobe and hold counts. A same-kind follow-on request starts max(2, cycle_count − L) clocks after the acknowledge. The bench samples every output at the falling edge and counts per-cycle occupancy of each strobe. It compares those counts, the start offset and the acknowledge position against values it derives arithmetically from the picosecond parameters and the device model's ready delay. The device model returns the number of clocks the read strobe has been low, so the captured word shows exactly which strobe cycle was sampled.

// File: rtl/async_bus_seq_pkg.sv
`timescale 1ns/1ps
package async_bus_seq_pkg;

  // Picoseconds to clocks, rounded up, never below one clock.
  function automatic int unsigned toCycles(input int unsigned ps, input int unsigned periodPs);
    int unsigned c;
    c = (ps + periodPs - 1) / periodPs;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned minU(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_DSU, PH_WAIT, PH_STRB, PH_HOLD, PH_DONE
  } phaseT;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;
    logic adsOn;
    logic csOn;
    logic rdOn;
    logic wrOn;
    logic oeOn;
    logic capture;
    logic setErr;
    logic ack;
  } strobeT;

endpackage

// File: rtl/async_bus_seq_ctrl.sv
`timescale 1ns/1ps
module async_bus_seq_ctrl
  import async_bus_seq_pkg::*;
#(
  parameter int unsigned ADS_CNT     = 1,
  parameter int unsigned DSU_CNT     = 1,
  parameter int unsigned RDY_CNT     = 1,
  parameter int unsigned RD_CNT      = 1,
  parameter int unsigned WR_CNT      = 1,
  parameter int unsigned CAP_CNT     = 1,
  parameter int unsigned HOLD_WR_CNT = 1,
  parameter int unsigned HOLD_RD_CNT = 1,
  parameter int unsigned RD_GAP      = 1,
  parameter int unsigned WR_GAP      = 1,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned GAP_W       = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   hostValid,
  input  logic   hostWr,
  input  logic   busRdy,
  output strobeT ctl
);

  phaseT              phase;
  logic [CNT_W-1:0]   cnt;
  logic [GAP_W-1:0]   rdGap, wrGap;
  logic               isWr, timedOut;
  int unsigned        lenSel;
  logic               lastCnt, startOk, waitExpire;

  always_comb begin
    unique case (phase)
      PH_ADDR: lenSel = ADS_CNT;
      PH_DSU:  lenSel = DSU_CNT;
      PH_WAIT: lenSel = RDY_CNT;
      PH_STRB: lenSel = isWr ? WR_CNT : RD_CNT;
      PH_HOLD: lenSel = isWr ? HOLD_WR_CNT : HOLD_RD_CNT;
      default: lenSel = 1;
    endcase
  end

  assign lastCnt    = (cnt == CNT_W'(lenSel - 1));
  assign startOk    = hostValid && (hostWr ? (wrGap == '0) : (rdGap == '0));
  assign waitExpire = (phase == PH_WAIT) && !busRdy && lastCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      isWr     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (startOk) begin
          phase    <= PH_ADDR;
          cnt      <= '0;
          isWr     <= hostWr;
          timedOut <= 1'b0;
        end
        PH_ADDR: if (lastCnt) begin
          cnt   <= '0;
          phase <= isWr ? PH_DSU : PH_WAIT;
        end else cnt <= cnt + 1'b1;
        PH_DSU: if (lastCnt) begin
          cnt   <= '0;
          phase <= PH_WAIT;
        end else cnt <= cnt + 1'b1;
        PH_WAIT: if (busRdy) begin
          cnt   <= '0;
          phase <= PH_STRB;
        end else if (lastCnt) begin
          cnt      <= '0;
          timedOut <= 1'b1;
          phase    <= PH_HOLD;
        end else cnt <= cnt + 1'b1;
        PH_STRB: if (lastCnt) begin
          cnt   <= '0;
          phase <= PH_HOLD;
        end else cnt <= cnt + 1'b1;
        PH_HOLD: if (lastCnt) begin
          cnt   <= '0;
          phase <= PH_DONE;
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Same-kind spacing: loaded at acceptance, counts down to zero.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdGap <= '0;
      wrGap <= '0;
    end else begin
      if (phase == PH_IDLE && startOk && !hostWr) rdGap <= GAP_W'(RD_GAP - 1);
      else if (rdGap != '0)                      rdGap <= rdGap - 1'b1;
      if (phase == PH_IDLE && startOk && hostWr)  wrGap <= GAP_W'(WR_GAP - 1);
      else if (wrGap != '0)                      wrGap <= wrGap - 1'b1;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (phase == PH_IDLE) && startOk;
    ctl.adsOn   = (phase == PH_ADDR);
    ctl.csOn    = (phase != PH_IDLE) && (phase != PH_DONE);
    ctl.rdOn    = (phase == PH_STRB) && !isWr;
    ctl.wrOn    = (phase == PH_STRB) && isWr;
    ctl.oeOn    = isWr && (phase == PH_DSU || phase == PH_WAIT ||
                           phase == PH_STRB || phase == PH_HOLD);
    ctl.capture = (phase == PH_STRB) && !isWr && (cnt == CNT_W'(CAP_CNT - 1));
    ctl.setErr  = waitExpire;
    ctl.ack     = (phase == PH_DONE);
  end

  // R9: acknowledge lasts a single clock
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ack |=> !ctl.ack);

  // R6: a strobe only begins after ready was seen
  a_r6_strobe_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.rdOn || ctl.wrOn) |-> $past(busRdy));

  // R7: an abandoned wait never produces a strobe
  a_r7_timeout_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> !(ctl.rdOn || ctl.wrOn));

endmodule

// File: rtl/async_bus_seq_dp.sv
`timescale 1ns/1ps
module async_bus_seq_dp
  import async_bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [BE_W-1:0]   hostBe,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostErr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBeN,
  output logic              busAds,
  output logic              busCsN,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe,
  input  logic [DATA_W-1:0] busDin
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic [BE_W-1:0]   beQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else if (ctl.load) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
      beQ    <= hostBe;
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else if (ctl.capture) begin
      rdataQ <= busDin;
    end else if (ctl.setErr) begin
      rdataQ <= '0;
      errQ   <= 1'b1;
    end
  end

  assign busAddr   = addrQ;
  assign busBeN    = ctl.csOn ? ~beQ : '1;
  assign busAds    = ctl.adsOn;
  assign busCsN    = !ctl.csOn;
  assign busRdN    = !ctl.rdOn;
  assign busWrN    = !ctl.wrOn;
  assign busDout   = wdataQ;
  assign busOe     = ctl.oeOn;
  assign hostAck   = ctl.ack;
  assign hostRdata = rdataQ;
  assign hostErr   = errQ;

  // R4: strobes only inside a selected cycle
  a_r4_strobe_in_select: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN || !busWrN) |-> !busCsN);

  // R5: the data driver is never on while reading
  a_r5_oe_not_read: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> busRdN);

  // R3: address steady throughout the select period
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && $past(!busCsN)) |-> $stable(busAddr));

endmodule

// File: rtl/async_bus_seq.sv
`timescale 1ns/1ps
module async_bus_seq
  import async_bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_ADDR_SU     = 10000,
  parameter int unsigned T_ADS_W       = 12000,
  parameter int unsigned T_CS_W        = 20000,
  parameter int unsigned T_ADDR_H      = 5000,
  parameter int unsigned T_CS_H        = 9000,
  parameter int unsigned T_DATA_H      = 3000,
  parameter int unsigned T_DATA_SU     = 8000,
  parameter int unsigned T_RD_W        = 30000,
  parameter int unsigned T_WR_W        = 20000,
  parameter int unsigned T_RD_CYC      = 160000,
  parameter int unsigned T_WR_CYC      = 40000,
  parameter int unsigned T_DATA_OUT    = 17000,
  parameter int unsigned T_DATA_INV    = 30000,
  parameter int unsigned T_RDY_MAX     = 48000,
  localparam int unsigned BE_W         = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [BE_W-1:0]   hostBe,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostErr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBeN,
  output logic              busAds,
  output logic              busCsN,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busRdy
);

  localparam int unsigned P       = CLK_PERIOD_PS;
  localparam int unsigned ADS_CNT = toCycles(maxU(maxU(T_ADDR_SU, T_ADS_W), T_CS_W), P);
  localparam int unsigned HWR_CNT = toCycles(maxU(maxU(T_DATA_H, T_CS_H), T_ADDR_H), P);
  localparam int unsigned HRD_CNT = maxU(HWR_CNT, toCycles(T_DATA_INV, P));
  localparam int unsigned DSU_CNT = toCycles(T_DATA_SU, P);
  localparam int unsigned RDY_CNT = toCycles(T_RDY_MAX, P);
  localparam int unsigned RD_CNT  = toCycles(T_RD_W, P);
  localparam int unsigned WR_CNT  = toCycles(T_WR_W, P);
  localparam int unsigned CAP_CNT = minU(toCycles(T_DATA_OUT, P), RD_CNT);
  localparam int unsigned RD_GAP  = toCycles(T_RD_CYC, P);
  localparam int unsigned WR_GAP  = toCycles(T_WR_CYC, P);
  localparam int unsigned MAX_PH  = maxU(maxU(maxU(ADS_CNT, HRD_CNT), maxU(DSU_CNT, RDY_CNT)),
                                         maxU(RD_CNT, WR_CNT));
  localparam int unsigned CNT_W   = $clog2(MAX_PH + 1);
  localparam int unsigned GAP_W   = $clog2(maxU(RD_GAP, WR_GAP) + 1);

  strobeT ctl;

  async_bus_seq_ctrl #(
    .ADS_CNT(ADS_CNT), .DSU_CNT(DSU_CNT), .RDY_CNT(RDY_CNT),
    .RD_CNT(RD_CNT), .WR_CNT(WR_CNT), .CAP_CNT(CAP_CNT),
    .HOLD_WR_CNT(HWR_CNT), .HOLD_RD_CNT(HRD_CNT),
    .RD_GAP(RD_GAP), .WR_GAP(WR_GAP), .CNT_W(CNT_W), .GAP_W(GAP_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWr(hostWr),
    .busRdy(busRdy), .ctl(ctl)
  );

  async_bus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .hostAck(hostAck), .hostRdata(hostRdata), .hostErr(hostErr),
    .busAddr(busAddr), .busBeN(busBeN), .busAds(busAds), .busCsN(busCsN),
    .busRdN(busRdN), .busWrN(busWrN), .busDout(busDout), .busOe(busOe),
    .busDin(busDin)
  );

endmodule

// File: tb/async_bus_seq_test.sv
`timescale 1ns/1ps
module async_bus_seq_test;

  localparam int PER = 8000;
  localparam int T_ADDR_SU = 10000, T_ADS_W = 12000, T_CS_W = 20000;
  localparam int T_ADDR_H = 5000, T_CS_H = 9000, T_DATA_H = 3000;
  localparam int T_DATA_SU = 0, T_RD_W = 30000, T_WR_W = 20000;
  localparam int T_RD_CYC = 160000, T_WR_CYC = 40000;
  localparam int T_DATA_OUT = 17000, T_DATA_INV = 30000, T_RDY_MAX = 48000;

  function automatic int cyc(input int ps);
    int c;
    c = ps / PER + ((ps % PER) != 0 ? 1 : 0);
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction

  localparam int E_ADS   = cyc(mx(mx(T_ADDR_SU, T_ADS_W), T_CS_W));
  localparam int E_HOLDW = cyc(mx(mx(T_ADDR_H, T_CS_H), T_DATA_H));
  localparam int E_HOLDR = mx(E_HOLDW, cyc(T_DATA_INV));
  localparam int E_DSU   = cyc(T_DATA_SU);
  localparam int E_RD    = cyc(T_RD_W);
  localparam int E_WR    = cyc(T_WR_W);
  localparam int E_CAP   = (cyc(T_DATA_OUT) < E_RD) ? cyc(T_DATA_OUT) : E_RD;
  localparam int E_RDY   = cyc(T_RDY_MAX);
  localparam int E_RDCYC = cyc(T_RD_CYC);
  localparam int E_WRCYC = cyc(T_WR_CYC);

  logic clk = 1'b0, rstN = 1'b0;
  logic hostValid = 1'b0, hostWr = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [3:0]  hostBe = '0;
  logic hostAck, hostErr, busAds, busCsN, busRdN, busWrN, busOe, busRdy;
  logic [31:0] hostRdata, busDout, busDin;
  logic [15:0] busAddr;
  logic [3:0]  busBeN;

  always #4 clk = ~clk;

  async_bus_seq #(
    .ADDR_W(16), .DATA_W(32), .CLK_PERIOD_PS(PER),
    .T_ADDR_SU(T_ADDR_SU), .T_ADS_W(T_ADS_W), .T_CS_W(T_CS_W),
    .T_ADDR_H(T_ADDR_H), .T_CS_H(T_CS_H), .T_DATA_H(T_DATA_H),
    .T_DATA_SU(T_DATA_SU), .T_RD_W(T_RD_W), .T_WR_W(T_WR_W),
    .T_RD_CYC(T_RD_CYC), .T_WR_CYC(T_WR_CYC), .T_DATA_OUT(T_DATA_OUT),
    .T_DATA_INV(T_DATA_INV), .T_RDY_MAX(T_RDY_MAX)
  ) uut (.*);

  // Device model: ready after devDelay selected clocks; read word = {address, strobe clock index}.
  int devDelay = 0;
  logic [15:0] csRun = '0, rdRun = '0;
  always_ff @(posedge clk) begin
    csRun <= busCsN ? 16'd0 : csRun + 16'd1;
    rdRun <= busRdN ? 16'd0 : rdRun + 16'd1;
  end
  assign busRdy = !busCsN && (int'(csRun) >= devDelay);
  assign busDin = !busRdN ? {busAddr, rdRun} : 32'hBAD0_BAD0;

  int nChecks = 0, nFails = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int rStart, rTot, rAds, rCs, rRd, rWr, rOe, rOeBad, rDataBad, rAddrBad;
  logic [31:0] rRdata;
  logic rErr;
  int lastL;

  task automatic doAccess(input bit wr, input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] be, input int dly);
    int n;
    bit started;
    devDelay = dly;
    hostWr = wr; hostAddr = a; hostWdata = d; hostBe = be; hostValid = 1'b1;
    n = 0; started = 0; rStart = 0; rTot = 0;
    rAds = 0; rCs = 0; rRd = 0; rWr = 0; rOe = 0; rOeBad = 0; rDataBad = 0; rAddrBad = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (!started && busAds) begin started = 1; rStart = n; end
      if (busAds) rAds++;
      if (!busCsN) begin
        rCs++;
        if (busAddr != a || busBeN != ~be) rAddrBad++;
      end
      if (!busRdN) rRd++;
      if (!busWrN) rWr++;
      if (busOe) begin
        rOe++;
        if (!wr || busCsN) rOeBad++;
        if (busDout != d) rDataBad++;
      end
      if (hostAck) begin
        hostValid = 1'b0;
        rRdata = hostRdata; rErr = hostErr;
        rTot = n - rStart + 1;
        break;
      end
      if (n > 2000) break;
    end
  endtask

  task automatic verify(input bit wr, input logic [15:0] a, input int dly, input int expStart);
    int w, wEff, strobe, hold, dsu, L;
    bit to;
    dsu = wr ? E_DSU : 0;
    w = mx(1, dly - E_ADS - dsu + 1);
    to = (w > E_RDY);
    wEff = to ? E_RDY : w;
    strobe = to ? 0 : (wr ? E_WR : E_RD);
    hold = wr ? E_HOLDW : E_HOLDR;
    L = E_ADS + dsu + wEff + strobe + hold;
    lastL = L;
    check(rStart == expStart, "R8", "start offset", rStart, expStart);
    check(rAds == E_ADS, "R2", "address strobe clocks", rAds, E_ADS);
    check(rCs == L, "R3", "select clocks (R6 wait included)", rCs, L);
    check(rTot == L + 1, "R9", "ack position", rTot, L + 1);
    check(rAddrBad == 0, "R9", "address/byte-enable errors", rAddrBad, 0);
    check(rRd == ((!wr && !to) ? E_RD : 0), "R4", "read strobe clocks", rRd, (!wr && !to) ? E_RD : 0);
    check(rWr == ((wr && !to) ? E_WR : 0), "R5", "write strobe clocks", rWr, (wr && !to) ? E_WR : 0);
    check(rOe == (wr ? L - E_ADS : 0), "R5", "output enable clocks", rOe, wr ? L - E_ADS : 0);
    check(rOeBad == 0 && rDataBad == 0, "R5", "drive errors", rOeBad + rDataBad, 0);
    check(rErr == to, "R7", "error flag", rErr, to);
    if (!wr) begin
      logic [31:0] expD;
      expD = to ? 32'd0 : {a, 16'(E_CAP - 1)};
      check(rRdata == expD, to ? "R7" : "R4", "read word", rRdata, expD);
    end
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int expS;
    repeat (3) @(negedge clk);
    // R10: outputs idle while in reset
    check(busCsN && busRdN && busWrN && !busAds && !busOe && !hostAck, "R10",
          "idle outputs in reset", {busCsN, busRdN, busWrN, busAds, busOe, hostAck}, 6'b111000);
    rstN = 1'b1;
    @(negedge clk);
    check(busCsN && busRdN && busWrN && !busAds && !busOe && !hostAck, "R10",
          "idle outputs after reset", {busCsN, busRdN, busWrN, busAds, busOe, hostAck}, 6'b111000);
    // R1: conversions including the zero-valued setup figure
    check(E_DSU == 1 && E_ADS == 3 && E_HOLDR == 4, "R1", "converted counts",
          E_DSU * 100 + E_ADS * 10 + E_HOLDR, 134);

    // Sweep ready delays across both kinds, covering the R6 wait and the R7 timeout boundary.
    for (int wr = 0; wr < 2; wr++) begin
      for (int dly = 0; dly < 12; dly++) begin
        logic [15:0] a;
        a = 16'(16'h1000 + dly * 17 + wr * 256);
        repeat (25) @(negedge clk);
        doAccess(wr[0], a, 32'hA5000000 + 32'(dly * 4099), 4'(dly + 1), dly);
        verify(wr[0], a, dly, 1);
      end
    end

    // R8: read followed at once by read
    repeat (25) @(negedge clk);
    doAccess(1'b0, 16'h2222, 32'h0, 4'hF, 0);
    verify(1'b0, 16'h2222, 0, 1);
    expS = mx(2, E_RDCYC - lastL);
    doAccess(1'b0, 16'h3333, 32'h0, 4'h3, 0);
    verify(1'b0, 16'h3333, 0, expS);

    // R8: write followed at once by write (cycle time shorter than access)
    repeat (25) @(negedge clk);
    doAccess(1'b1, 16'h4444, 32'h12345678, 4'hC, 0);
    verify(1'b1, 16'h4444, 0, 1);
    expS = mx(2, E_WRCYC - lastL);
    doAccess(1'b1, 16'h5555, 32'h9ABCDEF0, 4'h1, 0);
    verify(1'b1, 16'h5555, 0, expS);

    // R8/R9: read then write at once, no cross-kind spacing
    repeat (25) @(negedge clk);
    doAccess(1'b0, 16'h6666, 32'h0, 4'hF, 2);
    verify(1'b0, 16'h6666, 2, 1);
    doAccess(1'b1, 16'h7777, 32'hCAFEF00D, 4'h6, 0);
    verify(1'b1, 16'h7777, 0, 2);

    // R7 then R8: timed-out read followed at once by a good read
    repeat (25) @(negedge clk);
    doAccess(1'b0, 16'h8888, 32'h0, 4'hF, 200);
    verify(1'b0, 16'h8888, 200, 1);
    expS = mx(2, E_RDCYC - lastL);
    doAccess(1'b0, 16'h9999, 32'h0, 4'hF, 0);
    verify(1'b0, 16'h9999, 0, expS);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule